// File: doc/BRIEF.md
# Per-Processor Interrupt Signalling and Acknowledge Interface

This block sits between an interrupt distributor and one processor. Each cycle the distributor offers a single best candidate: an interrupt number, its priority value, a trigger-type flag and, for software-raised interrupts, the number of the processor that raised it. The block compares the candidate's priority with a programmable threshold and, when signalling is enabled and no earlier interrupt is still being serviced, raises the request line to the processor.

Software talks to the block over a simple 32-bit register bus with four word-addressed registers. Reading the acknowledge register has side effects. When a candidate qualifies, the read returns its number, marks it as being serviced, and pulses a take strobe back to the distributor. For edge-triggered interrupts the strobe also tells the distributor to clear the pending bit. When no candidate qualifies, the read returns the spurious number 1023 and changes nothing. Writing the number of the serviced interrupt to the completion register ends service, and the request line may rise again.

The block tracks one interrupt in service at a time. Preemption and priority grouping are not provided. A serviced interrupt blocks all new signalling until it is completed.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset the request line is low, the control and threshold registers read 0, no interrupt is in service, and no take or done strobe is given.
- R2: While control bit 0 (word address 0) is 0, the request line stays low and an acknowledge read returns 1023.
- R3: The request line is high only when a valid candidate's priority value is strictly lower than the 8-bit threshold (word address 1, bits [7:0]), signalling is enabled and nothing is in service; a priority equal to the threshold is not signalled.
- R4: A successful acknowledge read (word address 2) returns the interrupt number in bits [9:0]. For numbers below 16, bits [12:10] hold the source processor; otherwise they are 0. Bits [31:13] are 0. Read data appears the cycle after the read strobe.
- R5: An acknowledge read with no qualifying candidate returns 1023, gives no take strobe and leaves the service state unchanged.
- R6: A successful acknowledge gives, in the cycle of the read, a take strobe with the interrupt number, and a pending-clear flag equal to the candidate's edge flag. From the next cycle the interrupt is in service.
- R7: While an interrupt is in service, the request line is low, even with a qualifying candidate present.
- R8: A write to word address 3 whose bits [9:0] equal the in-service number gives a done strobe with that number in the write cycle and ends service, so that the request line can rise again.
- R9: A completion write with any other number gives no done strobe and leaves the interrupt in service, so the request line stays low.
- R10: Control and threshold registers read back what was written, with all unused bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 control, 1 threshold, 2 acknowledge, 3 completion |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read strobe |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | 10 | Candidate interrupt number |
| cand_prio | input | 8 | Candidate priority value (lower is more urgent) |
| cand_src | input | 3 | Raising processor for software interrupts |
| cand_edge | input | 1 | Candidate is edge-triggered |
| irq_req | output | 1 | Interrupt request to the processor |
| take_valid | output | 1 | Candidate taken by an acknowledge read |
| take_id | output | 10 | Number of the taken interrupt |
| take_clr_pend | output | 1 | Distributor must clear the pending bit |
| done_valid | output | 1 | In-service interrupt completed |
| done_id | output | 10 | Number of the completed interrupt |

## Verification
The assertions assume that the distributor holds its candidate steady within a cycle and that at most one register access is in flight per cycle, so a take and a done strobe can never coincide. They also assume that no bus access is issued while reset is high. The stimulus changes candidate fields and bus signals only on falling edges. It issues each access as a single-cycle strobe and keeps the bus idle throughout reset.

// File: rtl/cpif_pkg.sv
package cpif_pkg;

    localparam int ID_W      = 10;
    localparam int PRIO_W    = 8;
    localparam int SRC_W     = 3;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 2;
    localparam int SGI_LIMIT = 16;
    localparam logic [ID_W-1:0] SPURIOUS_ID = ID_W'(1023);

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL  = 2'd0,
        RA_THRSH = 2'd1,
        RA_ACK   = 2'd2,
        RA_DONE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              valid;
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
        logic [SRC_W-1:0]  src;
        logic              edge_trig;
    } cand_t;

    function automatic logic [DATA_W-1:0] pack_ack(input logic hit, input cand_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        if (hit) begin
            w[ID_W-1:0] = c.id;
            if (c.id < ID_W'(SGI_LIMIT))
                w[ID_W+SRC_W-1:ID_W] = c.src;
        end else begin
            w[ID_W-1:0] = SPURIOUS_ID;
        end
        return w;
    endfunction

endpackage

// File: rtl/cpif_regs.sv
module cpif_regs
    import cpif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] ack_word,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sig_en,
    output logic [PRIO_W-1:0] thresh,
    output logic              ack_rd,
    output logic              done_wr,
    output logic [ID_W-1:0]   done_wid
);

    logic wr_ctrl, wr_thr;

    always_comb begin
        wr_ctrl  = bus_sel && bus_we && (bus_addr == RA_CTRL);
        wr_thr   = bus_sel && bus_we && (bus_addr == RA_THRSH);
        ack_rd   = !rst && bus_sel && !bus_we && (bus_addr == RA_ACK);
        done_wr  = !rst && bus_sel && bus_we && (bus_addr == RA_DONE);
        done_wid = bus_wdata[ID_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_en <= 1'b0;
            thresh <= '0;
        end else begin
            if (wr_ctrl) sig_en <= bus_wdata[0];
            if (wr_thr)  thresh <= bus_wdata[PRIO_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_sel && !bus_we) begin
            case (bus_addr)
                RA_CTRL:  bus_rdata <= DATA_W'(sig_en);
                RA_THRSH: bus_rdata <= DATA_W'(thresh);
                RA_ACK:   bus_rdata <= ack_word;
                default:  bus_rdata <= '0;
            endcase
        end
    end

    // R10
    thresh_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_thr |=> $stable(thresh));

endmodule

// File: rtl/cpif_select.sv
module cpif_select
    import cpif_pkg::*;
(
    input  cpif_pkg::cand_t   cand,
    input  logic              sig_en,
    input  logic [PRIO_W-1:0] thresh,
    input  logic              in_service,
    output logic              qualifies,
    output logic [DATA_W-1:0] ack_word
);

    logic below;

    always_comb begin
        below     = cand.prio < thresh;
        qualifies = cand.valid && below && sig_en && !in_service;
        ack_word  = pack_ack(qualifies, cand);
    end

endmodule

// File: rtl/cpif_active.sv
module cpif_active
    import cpif_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic [ID_W-1:0] take_num,
    input  logic            done_wr,
    input  logic [ID_W-1:0] done_wid,
    output logic            in_service,
    output logic [ID_W-1:0] svc_id,
    output logic            done_hit
);

    always_comb done_hit = done_wr && in_service && (done_wid == svc_id);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_service <= 1'b0;
            svc_id     <= '0;
        end else if (take) begin
            in_service <= 1'b1;
            svc_id     <= take_num;
        end else if (done_hit) begin
            in_service <= 1'b0;
        end
    end

    // R6
    take_marks_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (in_service && svc_id == $past(take_num)));

    // R8
    done_clears_chk: assert property (@(posedge clk) disable iff (rst)
        done_hit |=> !in_service);

    // R9
    stray_done_chk: assert property (@(posedge clk) disable iff (rst)
        (done_wr && !done_hit && !take) |=> ($stable(in_service) && $stable(svc_id)));

endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
    import cpif_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        cand_valid,
    input  logic [9:0]  cand_id,
    input  logic [7:0]  cand_prio,
    input  logic [2:0]  cand_src,
    input  logic        cand_edge,
    output logic        irq_req,
    output logic        take_valid,
    output logic [9:0]  take_id,
    output logic        take_clr_pend,
    output logic        done_valid,
    output logic [9:0]  done_id
);

    cand_t             cand;
    logic              sig_en;
    logic [PRIO_W-1:0] thresh;
    logic              ack_rd, done_wr;
    logic [ID_W-1:0]   done_wid;
    logic [DATA_W-1:0] ack_word;
    logic              qualifies, in_service, done_hit;
    logic [ID_W-1:0]   svc_id;

    always_comb begin
        cand.valid     = cand_valid;
        cand.id        = cand_id;
        cand.prio      = cand_prio;
        cand.src       = cand_src;
        cand.edge_trig = cand_edge;
    end

    cpif_regs u_regs (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ack_word(ack_word),
        .bus_rdata(bus_rdata), .sig_en(sig_en), .thresh(thresh),
        .ack_rd(ack_rd), .done_wr(done_wr), .done_wid(done_wid)
    );

    cpif_select u_select (
        .cand(cand), .sig_en(sig_en), .thresh(thresh),
        .in_service(in_service), .qualifies(qualifies), .ack_word(ack_word)
    );

    cpif_active u_active (
        .clk(clk), .rst(rst), .take(take_valid), .take_num(cand_id),
        .done_wr(done_wr), .done_wid(done_wid), .in_service(in_service),
        .svc_id(svc_id), .done_hit(done_hit)
    );

    always_comb begin
        irq_req       = qualifies;
        take_valid    = ack_rd && qualifies;
        take_id       = cand_id;
        take_clr_pend = take_valid && cand_edge;
        done_valid    = done_hit;
        done_id       = svc_id;
    end

    // R7
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        in_service |-> !irq_req);

    // R3
    take_prio_chk: assert property (@(posedge clk) disable iff (rst)
        take_valid |-> (cand_prio < thresh));

    // R4
    ack_data_chk: assert property (@(posedge clk) disable iff (rst)
        $past(take_valid) |-> (bus_rdata[9:0] == $past(take_id) && bus_rdata[31:13] == '0));

    // R5
    spurious_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && !qualifies) |=> (bus_rdata == 32'd1023));

    // R2
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !sig_en |-> !irq_req);

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({take_valid, done_valid}));

endmodule

// File: tb/test_cpu_irq_iface.sv
module test_cpu_irq_iface;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_we;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        cand_valid, cand_edge;
    logic [9:0]  cand_id;
    logic [7:0]  cand_prio;
    logic [2:0]  cand_src;
    logic        irq_req, take_valid, take_clr_pend, done_valid;
    logic [9:0]  take_id, done_id;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic        cap_take, cap_clr, cap_done;
    logic [9:0]  cap_tid, cap_did;
    logic [31:0] rd;

    always #10 clk = ~clk;

    cpu_irq_iface i_cpu_irq_iface (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cand_valid(cand_valid), .cand_id(cand_id), .cand_prio(cand_prio),
        .cand_src(cand_src), .cand_edge(cand_edge), .irq_req(irq_req),
        .take_valid(take_valid), .take_id(take_id), .take_clr_pend(take_clr_pend),
        .done_valid(done_valid), .done_id(done_id)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        #2;
        cap_done = done_valid; cap_did = done_id;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #2;
        cap_take = take_valid; cap_tid = take_id; cap_clr = take_clr_pend;
        @(negedge clk);
        bus_sel = 1'b0;
        rd = bus_rdata;
    endtask

    task automatic offer(input logic v, input logic [9:0] id, input logic [7:0] p,
                         input logic [2:0] s, input logic e);
        @(negedge clk);
        cand_valid = v; cand_id = id; cand_prio = p; cand_src = s; cand_edge = e;
        #2;
    endtask

    task automatic t_reset;
        check("R1", "irq after reset", 32'(irq_req), 0);
        check("R1", "take after reset", 32'(take_valid), 0);
        check("R1", "done after reset", 32'(done_valid), 0);
        bus_read(2'd0); check("R1", "control reset", rd, 0);
        bus_read(2'd1); check("R1", "threshold reset", rd, 0);
    endtask

    task automatic t_readback;
        bus_write(2'd0, 32'hFFFF_FFFF);
        bus_read(2'd0); check("R10", "control readback", rd, 32'h1);
        bus_write(2'd1, 32'hABCD_12FF);
        bus_read(2'd1); check("R10", "threshold readback", rd, 32'hFF);
        bus_write(2'd1, 32'h0000_00F0);
        bus_read(2'd1); check("R10", "threshold F0", rd, 32'hF0);
    endtask

    task automatic t_threshold;
        offer(1, 10'd40, 8'hA0, 3'd0, 1);
        check("R3", "prio A0 < F0", 32'(irq_req), 1);
        offer(1, 10'd40, 8'hF0, 3'd0, 1);
        check("R3", "prio equal to threshold", 32'(irq_req), 0);
        offer(1, 10'd40, 8'hEF, 3'd0, 1);
        check("R3", "prio EF", 32'(irq_req), 1);
        offer(0, 10'd40, 8'h10, 3'd0, 1);
        check("R3", "no valid candidate", 32'(irq_req), 0);
    endtask

    task automatic t_disable;
        offer(1, 10'd40, 8'h20, 3'd0, 1);
        bus_write(2'd0, 32'h0);
        #2; check("R2", "irq while disabled", 32'(irq_req), 0);
        bus_read(2'd2);
        check("R2", "ack while disabled", rd, 32'd1023);
        check("R2", "no take while disabled", 32'(cap_take), 0);
        bus_write(2'd0, 32'h1);
        #2; check("R2", "irq re-enabled", 32'(irq_req), 1);
    endtask

    task automatic t_spurious;
        offer(1, 10'd50, 8'hF8, 3'd0, 1);
        bus_read(2'd2);
        check("R5", "spurious value", rd, 32'd1023);
        check("R5", "spurious no take", 32'(cap_take), 0);
        offer(1, 10'd50, 8'h30, 3'd0, 1);
        check("R5", "state unchanged after spurious", 32'(irq_req), 1);
    endtask

    task automatic t_edge_cycle;
        offer(1, 10'd40, 8'h30, 3'd5, 1);
        bus_read(2'd2);
        check("R6", "take strobe", 32'(cap_take), 1);
        check("R6", "take id", 32'(cap_tid), 40);
        check("R6", "edge pend clear", 32'(cap_clr), 1);
        check("R4", "ack value spi", rd, 32'd40);
        #2; check("R7", "irq low in service", 32'(irq_req), 0);
        bus_read(2'd2);
        check("R7", "second ack spurious while busy", rd, 32'd1023);
        bus_write(2'd3, 32'd41);
        check("R9", "no done for wrong id", 32'(cap_done), 0);
        #2; check("R9", "still in service", 32'(irq_req), 0);
        bus_write(2'd3, 32'd40);
        check("R8", "done strobe", 32'(cap_done), 1);
        check("R8", "done id", 32'(cap_did), 40);
        #2; check("R8", "irq rises after completion", 32'(irq_req), 1);
        bus_write(2'd3, 32'd40);
        check("R9", "repeat completion ignored", 32'(cap_done), 0);
    endtask

    task automatic t_sgi_level;
        offer(1, 10'd5, 8'h40, 3'd3, 0);
        bus_read(2'd2);
        check("R4", "sgi ack word", rd, 32'h0000_0C05);
        check("R6", "level no pend clear", 32'(cap_clr), 0);
        bus_write(2'd3, 32'd5);
        check("R8", "sgi done", 32'(cap_done), 1);
        offer(1, 10'd16, 8'h40, 3'd7, 0);
        bus_read(2'd2);
        check("R4", "id 16 no source bits", rd, 32'd16);
        bus_write(2'd3, 32'd16);
        check("R8", "id 16 done", 32'(cap_done), 1);
    endtask

    initial begin
        rst = 1'b1; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        cand_valid = 0; cand_id = 0; cand_prio = 0; cand_src = 0; cand_edge = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #2;
        t_reset;
        t_readback;
        t_threshold;
        t_disable;
        t_spurious;
        t_edge_cycle;
        t_sgi_level;
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule